// File: doc/BRIEF.md
# Peripheral Clock Control Slice

This block gives one peripheral its clock and its reset from a single 32-bit control word. Up to eight source clock-enable streams arrive as single-cycle pulses on the system clock. The block picks one of them, thins it by a small fractional ratio, gates it, and sends the result to the peripheral as an enable pulse. The same word holds a software reset release. That release is held back for a fixed settling time after the clock is switched on, so the peripheral never leaves reset without a running clock.

Software reads and writes the word over a plain write-enable/data port, and reads back the live value. While the clock runs, the source and ratio fields are locked. A build parameter can mark the slice as absent. An absent slice reads as all zeros and does nothing.

Top module: `pclk_slice`

## Requirements
- R1: After power-on reset, the register reads 0x8000_0000 when the slice is present, the enable output is low and the peripheral reset output is low (asserted).
- R2: Reads return the live register: bit 31 presence, bit 30 gate, bit 28 reset release, bits 26:24 source select, bit 3 multiplier field, bits 2:0 divisor field. Every other bit reads 0.
- R3: While the gate bit (30) is 0, the enable output stays low, whatever the source pulses do.
- R4: Only pulses on the source line chosen by bits 26:24 reach the divider. Pulses on the other seven lines have no effect.
- R5: With multiplier field m (bit 3) and divisor field d (bits 2:0), N selected input pulses after the gate is enabled produce floor(N*(m+1)/(d+1)) output pulses. Each output pulse comes one cycle after the input pulse that completes it.
- R6: A write updates bits 26:24, 3 and 2:0 only when the gate bit is 0 both before the write and in the written data. The gate and release bits update on every write.
- R7: When one write sets both the gate and the release bit starting from gate 0, the reset output rises exactly SETTLE_CYCLES cycles after the gate bit rises.
- R8: With the release bit at 0, the reset output is low.
- R9: The divider accumulator is cleared whenever the gate is off, so every enable starts from a zero remainder.
- R10: When the multiplier step is at least the divisor step ((m+1) >= (d+1)), every selected input pulse gives one output pulse.
- R11: With PRESENT = 0, reads return 0, writes are ignored, the enable output stays low and the reset output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Live register value |
| src_pulse_i | input | 8 | Source clock-enable pulses, one per source |
| clk_pulse_o | output | 1 | Divided, gated enable pulse to the peripheral |
| periph_rst_n_o | output | 1 | Active-low reset to the peripheral |

## Verification
The bench drives the selected source line in bursts while all seven other lines pulse on every cycle. A design that decodes the select field wrongly therefore returns pulse counts far from the expected ratio. Ratio runs cover plain integer division, fractional 2/3 and the pass-through cases with divisor 0 and 1. Two short runs back to back with divisor 4 show the remainder clearing: a design that keeps its remainder across a re-enable fires on the second run. Writes that try to change the fields with the gate on, or in the very write that turns the gate off, must leave the readback unchanged. The reset output is sampled one cycle before and exactly at the end of the settling window. A second instance built as absent must read zero after an all-ones write.

// File: rtl/pclk_slice.sv
module pclk_slice #(
  parameter bit          PRESENT       = 1'b1,
  parameter int unsigned SETTLE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic [7:0]  src_pulse_i,
  output logic        clk_pulse_o,
  output logic        periph_rst_n_o
);
  localparam int CW = $clog2(SETTLE_CYCLES + 2);

  logic          gate_q, rel_q, mul_q, pulse_q;
  logic [2:0]    sel_q, div_q;
  logic [3:0]    acc_q;
  logic [CW-1:0] settle_q;

  logic       wr_ok, gate_nx, fields_open, gate_rise, hit, pass, fire;
  logic [3:0] step, lim, sum;
  logic       unused_bits;

  assign wr_ok       = wr_en & PRESENT;
  assign gate_nx     = wr_ok ? wr_data[30] : gate_q;
  assign fields_open = wr_ok & ~gate_q & ~wr_data[30];
  assign gate_rise   = ~gate_q & gate_nx;
  assign hit         = src_pulse_i[sel_q];
  assign step        = {3'b000, mul_q} + 4'd1;
  assign lim         = {1'b0, div_q} + 4'd1;
  assign sum         = acc_q + step;
  assign pass        = step >= lim;
  assign fire        = pass | (sum >= lim);
  assign unused_bits = ^{wr_data[31], wr_data[29], wr_data[27], wr_data[23:4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      rel_q  <= 1'b0;
      sel_q  <= 3'd0;
      div_q  <= 3'd0;
      mul_q  <= 1'b0;
    end else if (wr_ok) begin
      gate_q <= wr_data[30];
      rel_q  <= wr_data[28];
      if (fields_open) begin
        sel_q <= wr_data[26:24];
        mul_q <= wr_data[3];
        div_q <= wr_data[2:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 4'd0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= gate_q & gate_nx & hit & fire;
      if (!gate_q)
        acc_q <= 4'd0;
      else if (hit)
        acc_q <= pass ? 4'd0 : ((sum >= lim) ? sum - lim : sum);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      settle_q <= '0;
    else if (gate_rise)
      settle_q <= CW'(SETTLE_CYCLES);
    else if (settle_q != '0)
      settle_q <= settle_q - 1'b1;
  end

  assign clk_pulse_o    = pulse_q;
  assign periph_rst_n_o = rel_q & (settle_q == '0);
  assign rd_data = PRESENT ? {1'b1, gate_q, 1'b0, rel_q, 1'b0, sel_q, 20'd0, mul_q, div_q}
                           : 32'd0;

  AST_GATE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |-> !clk_pulse_o); // R3
  AST_PULSE_FROM_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    clk_pulse_o |-> $past(src_pulse_i[sel_q])); // R4
  AST_ACC_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> (acc_q <= {1'b0, div_q})); // R5
  AST_FIELDS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && gate_q) |=> ($stable(sel_q) && $stable(div_q) && $stable(mul_q))); // R6
  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> !periph_rst_n_o); // R7
  AST_RELEASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_q |-> !periph_rst_n_o); // R8
  AST_ABSENT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !PRESENT |-> (rd_data == 32'd0 && !clk_pulse_o && !periph_rst_n_o)); // R11
endmodule

// File: tb/pclk_slice_bench.sv
module pclk_slice_bench;
  localparam int SETTLE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = 32'd0;
  logic [7:0]  src = 8'd0;
  logic [31:0] rd_data, rd_abs;
  logic        pulse, prst_n, pulse_abs, prst_abs;

  int checks = 0;
  int failures = 0;
  int pulse_cnt = 0;
  bit clr_req = 1'b0;
  bit done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  pclk_slice #(.PRESENT(1'b1), .SETTLE_CYCLES(SETTLE)) u_pclk_slice (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .src_pulse_i(src), .clk_pulse_o(pulse), .periph_rst_n_o(prst_n));

  pclk_slice #(.PRESENT(1'b0), .SETTLE_CYCLES(SETTLE)) u_absent (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_abs),
    .src_pulse_i(src), .clk_pulse_o(pulse_abs), .periph_rst_n_o(prst_abs));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (clr_req) begin
      pulse_cnt = 0;
      clr_req = 1'b0;
    end else if (pulse) begin
      pulse_cnt++;
    end
    if (exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, pulse_cnt, e);
    end
  end

  task automatic reg_write(input logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic run_ratio(input int sel, input int d, input int m, input int n,
                           input bit gate_on, input string tag);
    logic [31:0] cfg;
    logic [7:0]  noise;
    int exp;
    cfg = (32'(sel) << 24) | (32'(m) << 3) | 32'(d);
    noise = ~(8'd1 << sel);
    reg_write(cfg);
    if (gate_on) reg_write(cfg | 32'h5000_0000);
    clr_req = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      src = noise | (8'd1 << sel);
    end
    @(posedge clk); #2;
    src = noise;
    repeat (3) @(posedge clk);
    if (!gate_on) exp = 0;
    else if (m + 1 >= d + 1) exp = n;
    else exp = (n * (m + 1)) / (d + 1);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk); @(negedge clk);
    src = 8'd0;
    reg_write(32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset value", rd_data, 32'h8000_0000);
    check("R1 pulse low", {31'd0, pulse}, 32'd0);
    check("R1 reset out low", {31'd0, prst_n}, 32'd0);

    reg_write(32'h3FFF_FFFF);
    @(negedge clk);
    check("R2 readback reserved zero", rd_data, 32'h9700_000F);
    reg_write(32'd0);

    run_ratio(1, 0, 0, 6, 1'b0, "R3 gate off no pulses");
    run_ratio(0, 2, 0, 9, 1'b1, "R4 R5 div3 on src0 with noise");
    run_ratio(5, 7, 0, 16, 1'b1, "R4 R5 div8 on src5");
    run_ratio(2, 2, 1, 12, 1'b1, "R5 ratio 2/3 on src2");
    run_ratio(7, 0, 1, 5, 1'b1, "R10 pass-through m1 d0");
    run_ratio(6, 1, 1, 7, 1'b1, "R10 pass-through m1 d1");
    run_ratio(3, 3, 0, 3, 1'b1, "R9 partial remainder");
    run_ratio(3, 3, 0, 1, 1'b1, "R9 remainder cleared");

    reg_write(32'h0200_000A);
    reg_write(32'h4200_000A);
    reg_write(32'h5300_0005);
    @(negedge clk);
    check("R6 fields locked while gate on", rd_data, 32'hD200_000A);
    reg_write(32'h4300_0005);
    @(negedge clk);
    check("R6 gate/release still update", rd_data, 32'hC200_000A);
    check("R8 release 0 keeps reset low", {31'd0, prst_n}, 32'd0);
    reg_write(32'h0500_0004);
    @(negedge clk);
    check("R6 locked in gate-off write", rd_data, 32'h8200_000A);
    reg_write(32'h0500_0004);
    @(negedge clk);
    check("R6 fields update with gate off", rd_data, 32'h8500_0004);

    reg_write(32'h0000_0000);
    reg_write(32'h5000_0000);
    repeat (SETTLE) @(negedge clk);
    check("R7 reset still low before settle", {31'd0, prst_n}, 32'd0);
    @(negedge clk);
    check("R7 reset released after settle", {31'd0, prst_n}, 32'd1);
    reg_write(32'h4000_0000);
    @(negedge clk);
    check("R8 clearing release asserts reset", {31'd0, prst_n}, 32'd0);
    reg_write(32'd0);

    reg_write(32'hFFFF_FFFF);
    src = 8'hFF;
    repeat (4) @(negedge clk);
    check("R11 absent reads zero", rd_abs, 32'd0);
    check("R11 absent no pulse", {31'd0, pulse_abs}, 32'd0);
    check("R11 absent reset held", {31'd0, prst_abs}, 32'd0);
    src = 8'd0;
    reg_write(32'd0);

    repeat (2) @(negedge clk);
    check("R5 scoreboard drained", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule